// File: doc/BRIEF.md
# Stop-Mode Wake and Clock-Enable Controller

This block manages the low-power stop state of a small microcontroller. A single 7-bit configuration word, written over a plain register strobe, picks which port pin (or which NOR of a group of port-2 pins) can bring the chip out of stop, the polarity of that wake condition, whether a reset pulse is inserted after the wake, and the rate of the system and timer clock enables. Reads return one sticky status bit that tells software the last start-up came from a stop wake rather than a cold power-on.

Outside stop, the block emits one-cycle clock-enable pulses for the system clock and the timer clock. The rate is the input clock divided by 1 or 2, optionally followed by a further divide by 16. Both enables run identically, so the timers and interrupt logic keep their clock during halt. A stop request freezes both enables. While stopped, the synchronised port pins are watched, and the chosen condition ends the stop. Depending on the configuration, the enables then restart at once or after a fixed 64-cycle internal reset pulse.

Top module: `stopwake_ctl`

## Requirements
- R1: `cfg_rdata` returns the wake flag in bit 7 and zero in bits 6:0; after power-on it reads 0x00.
- R2: The wake flag is set when a stop is ended by a wake condition. Only `por_n` clears it; the external reset `rst_n` leaves it unchanged.
- R3: Wake source field `cfg_wdata[4:2]`: 0 = no pin wake (reset only), 1..4 = `p3_in[0]`..`p3_in[3]`, 5 = `p2_in[7]`, 6 = NOR of `p2_in[3:0]`, 7 = NOR of `p2_in[7:0]`. Pins outside the chosen source have no effect.
- R4: `cfg_wdata[6]` sets the polarity. At 0 the stop ends when the selected signal is low; at 1 it ends when the signal is high.
- R5: If `cfg_wdata[5]` is 1, a wake drives `wake_rst` high for exactly 64 cycles with both enables low, and then the enables restart. If it is 0, `wake_rst` stays low and the enables restart in the cycle after the wake.
- R6: Enable period, from `cfg_wdata[1]` (1 = undivided input) and `cfg_wdata[0]` (1 = extra divide by 16): {0,0}=2, {1,0}=1, {0,1}=32, {1,1}=16 cycles.
- R7: Every wake from stop clears the divide-by-16 setting (bit 0).
- R8: From the cycle after `stop_req`, and for the whole stop, both `sclk_en` and `tclk_en` stay low. `stopped` is high.
- R9: After either reset the configuration is: polarity low, delay on, source 0, input divided by 2, divide-by-16 off. The block is running.
- R10: Pin activity while running does not wake the block or set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous external reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration bits 6:0 |
| cfg_rdata | output | 8 | Read data: flag in bit 7 |
| stop_req | input | 1 | Request to enter stop |
| p2_in | input | 8 | Port-2 pins, asynchronous |
| p3_in | input | 4 | Port-3 pins 0..3, asynchronous |
| sclk_en | output | 1 | System clock enable pulse |
| tclk_en | output | 1 | Timer clock enable pulse |
| wake_rst | output | 1 | Post-wake internal reset |
| stopped | output | 1 | High while in stop |

## Verification
The assertions assume that the port pins change slowly compared with the two-stage synchroniser. They also assume that `stop_req` only matters while the block runs and that the configuration is not rewritten in the same cycle as a wake. The stimulus holds every pin level for several cycles before a check. It enters stop only after the idle pin levels are settled to a non-waking value, and it performs writes only while the block is running.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_HOLD = 2'd2
    } sw_state_e;

    // field order follows the register bit layout, bit 6 down to bit 0
    typedef struct packed {
        logic       lvl_hi;
        logic       dly_on;
        logic [2:0] src;
        logic       full_rate;
        logic       pre16;
    } sw_cfg_t;

    localparam sw_cfg_t CFG_RESET = '{lvl_hi: 1'b0, dly_on: 1'b1, src: 3'd0,
                                      full_rate: 1'b0, pre16: 1'b0};

    localparam int PIN_W = 12;   // p3[3:0] in the low bits, p2[7:0] above

endpackage

// File: rtl/stopwake_src_sel.sv
module stopwake_src_sel
    import stopwake_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [7:0] p2_in,
    input  logic [3:0] p3_in,
    input  logic [2:0] src,
    input  logic       lvl_hi,
    output logic       hit
);

    logic [SYNC_STAGES-1:0][PIN_W-1:0] sync_d, sync_q;
    logic [PIN_W-1:0] pins;
    logic [7:0]       p2_s;
    logic [3:0]       p3_s;
    logic             raw;

    always_comb begin
        sync_d[0] = {p2_in, p3_in};
        for (int i = 1; i < SYNC_STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign pins = sync_q[SYNC_STAGES-1];
    assign p3_s = pins[3:0];
    assign p2_s = pins[PIN_W-1:4];

    always_comb begin
        case (src)
            3'd1:    raw = p3_s[0];
            3'd2:    raw = p3_s[1];
            3'd3:    raw = p3_s[2];
            3'd4:    raw = p3_s[3];
            3'd5:    raw = p2_s[7];
            3'd6:    raw = ~|p2_s[3:0];
            3'd7:    raw = ~|p2_s;
            default: raw = 1'b0;
        endcase
        hit = (src != 3'd0) && (raw == lvl_hi);
    end

    AST_SRC_NONE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (src == 3'd0) |-> !hit);  // R3

endmodule

// File: rtl/stopwake_clk_div.sv
module stopwake_clk_div #(
    parameter int PRE_DIV = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    input  logic full_rate,
    input  logic pre16,
    output logic en
);

    localparam int CNT_W = $clog2(2 * PRE_DIV);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        case ({full_rate, pre16})
            2'b10:   lim = '0;
            2'b00:   lim = CNT_W'(1);
            2'b11:   lim = CNT_W'(PRE_DIV - 1);
            default: lim = CNT_W'(2 * PRE_DIV - 1);
        endcase
        en = run && (cnt_q >= lim);
        if (!run)                cnt_d = '0;
        else if (cnt_q >= lim)   cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_EN_SPACED: assert property (@(posedge clk) disable iff (!por_n)
        en |=> (!en || lim == '0));  // R6
    AST_EN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!por_n)
        !run |-> !en);  // R8

endmodule

// File: rtl/stopwake_ctl.sv
module stopwake_ctl
    import stopwake_pkg::*;
#(
    parameter int DELAY_CYC   = 64,
    parameter int PRE_DIV     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [6:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       stop_req,
    input  logic [7:0] p2_in,
    input  logic [3:0] p3_in,
    output logic       sclk_en,
    output logic       tclk_en,
    output logic       wake_rst,
    output logic       stopped
);

    localparam int DLY_W = $clog2(DELAY_CYC);

    typedef struct packed {
        sw_state_e  state;
        sw_cfg_t    cfg;
        logic       flag;
        logic [DLY_W-1:0] dly;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic      wake_hit;
    logic      clk_en;

    stopwake_src_sel #(.SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk    (clk),
        .por_n  (por_n),
        .p2_in  (p2_in),
        .p3_in  (p3_in),
        .src    (r_q.cfg.src),
        .lvl_hi (r_q.cfg.lvl_hi),
        .hit    (wake_hit)
    );

    stopwake_clk_div #(.PRE_DIV(PRE_DIV)) div_i (
        .clk       (clk),
        .por_n     (por_n),
        .run       (r_q.state == ST_RUN),
        .full_rate (r_q.cfg.full_rate),
        .pre16     (r_q.cfg.pre16),
        .en        (clk_en)
    );

    always_comb begin
        r_d = r_q;
        if (!rst_n) begin
            r_d.state = ST_RUN;
            r_d.cfg   = CFG_RESET;
            r_d.dly   = '0;
        end else begin
            if (cfg_we) r_d.cfg = sw_cfg_t'(cfg_wdata);
            case (r_q.state)
                ST_RUN: begin
                    if (stop_req) r_d.state = ST_STOP;
                end
                ST_STOP: begin
                    if (wake_hit) begin
                        r_d.flag      = 1'b1;
                        r_d.cfg.pre16 = 1'b0;
                        r_d.dly       = '0;
                        r_d.state     = r_q.cfg.dly_on ? ST_HOLD : ST_RUN;
                    end
                end
                ST_HOLD: begin
                    r_d.dly = r_q.dly + 1'b1;
                    if (r_q.dly == DLY_W'(DELAY_CYC - 1)) r_d.state = ST_RUN;
                end
                default: r_d.state = ST_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q.state <= ST_RUN;
            r_q.cfg   <= CFG_RESET;
            r_q.flag  <= 1'b0;
            r_q.dly   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata = {r_q.flag, 7'b0};
    assign sclk_en   = clk_en;
    assign tclk_en   = clk_en;
    assign wake_rst  = (r_q.state == ST_HOLD);
    assign stopped   = (r_q.state == ST_STOP);

    AST_HALTED_NO_EN: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (r_q.state != ST_RUN) |-> !(sclk_en || tclk_en));  // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        r_q.flag |=> r_q.flag);  // R2
    AST_WAKE_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (r_q.state == ST_STOP && wake_hit) |=> r_q.flag);  // R2
    AST_WAKE_CLEARS_PRE16: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (r_q.state == ST_STOP && wake_hit) |=> !r_q.cfg.pre16);  // R7
    AST_HOLD_FROM_STOP: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        $rose(wake_rst) |-> $past(r_q.state == ST_STOP));  // R5
    AST_RUN_FLAG_STEADY: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (r_q.state == ST_RUN) |=> (r_q.flag == $past(r_q.flag)));  // R10

endmodule

// File: tb/stopwake_ctl_tb.sv
module stopwake_ctl_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       stop_req = 1'b0;
    logic [7:0] p2_in = '0;
    logic [3:0] p3_in = '0;
    logic       sclk_en, tclk_en, wake_rst, stopped;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    stopwake_ctl dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .stop_req(stop_req),
        .p2_in(p2_in), .p3_in(p3_in), .sclk_en(sclk_en), .tclk_en(tclk_en),
        .wake_rst(wake_rst), .stopped(stopped)
    );

    // vector: cfg[6:0], idle p3, idle p2, active p3, active p2, expect wake
    localparam int NV = 10;
    localparam logic [31:0] VEC [NV] = '{
        {7'h06, 4'hF, 8'hFF, 4'hE, 8'hFF, 1'b1},  // P3.0 low
        {7'h06, 4'hF, 8'hFF, 4'hD, 8'hFF, 1'b0},  // other pin low only
        {7'h4A, 4'h0, 8'h00, 4'h2, 8'h00, 1'b1},  // P3.1 high
        {7'h12, 4'hF, 8'hFF, 4'h7, 8'hFF, 1'b1},  // P3.3 low
        {7'h56, 4'h0, 8'h00, 4'h0, 8'h80, 1'b1},  // P2.7 high
        {7'h5A, 4'h0, 8'h01, 4'h0, 8'hF0, 1'b1},  // NOR low nibble, high
        {7'h1A, 4'h0, 8'h00, 4'h0, 8'hF0, 1'b0},  // NOR low nibble, upper bits ignored
        {7'h1E, 4'h0, 8'h00, 4'h0, 8'h80, 1'b1},  // NOR all eight, low
        {7'h02, 4'hF, 8'hFF, 4'h0, 8'h00, 1'b0},  // source 0 never wakes
        {7'h4E, 4'h0, 8'h00, 4'h4, 8'h00, 1'b1}   // P3.2 high
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [6:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1;
        stop_req = 1'b1;
        @(posedge clk); #1;
        stop_req = 1'b0;
    endtask

    task automatic ext_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic power_on();
        por_n = 1'b0;
        tick(2);
        por_n = 1'b1;
        tick(1);
    endtask

    task automatic count_en(input int n, output int s, output int t);
        s = 0; t = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sclk_en) s++;
            if (tclk_en) t++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected < 150000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int s, t, hold;
        logic [31:0] v;
        power_on();

        // reset state
        @(negedge clk);
        check("R1 rdata after power-on", cfg_rdata, 8'h00);
        check("R9 running after reset", stopped, 0);
        check("R9 no wake reset", wake_rst, 0);
        tick(2);
        count_en(64, s, t);
        check("R9 default rate /2 sclk", s, 32);
        check("R9 default rate /2 tclk", t, 32);

        // rates
        write_cfg(7'h02); tick(2); count_en(64, s, t);
        check("R6 full rate", s, 64);
        write_cfg(7'h03); tick(2); count_en(64, s, t);
        check("R6 full/16", s, 4);
        check("R6 tclk full/16", t, 4);
        write_cfg(7'h01); tick(2); count_en(64, s, t);
        check("R6 half/16", s, 2);
        write_cfg(7'h00); tick(2); count_en(64, s, t);
        check("R6 half", s, 32);

        // R10: pin activity while running
        p3_in = 4'hF; write_cfg(7'h06); tick(4);
        p3_in = 4'hE; tick(6);
        @(negedge clk);
        check("R10 no flag in run", cfg_rdata, 8'h00);
        check("R10 still running", stopped, 0);
        p3_in = 4'hF;

        // R8: enables frozen in stop
        write_cfg(7'h02); tick(3);
        pulse_stop();
        @(negedge clk);
        check("R8 stopped", stopped, 1);
        count_en(20, s, t);
        check("R8 sclk frozen", s, 0);
        check("R8 tclk frozen", t, 0);
        ext_reset();
        @(negedge clk);
        check("R9 rst_n leaves stop", stopped, 0);

        // vector table: R3, R4
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            p3_in = v[24:21]; p2_in = v[20:13];
            write_cfg(v[31:25]);
            tick(4);
            pulse_stop();
            @(negedge clk);
            check($sformatf("R3 vec%0d entered stop", k), stopped, 1);
            @(posedge clk); #1;
            p3_in = v[12:9]; p2_in = v[8:1];
            tick(6);
            @(negedge clk);
            check($sformatf("R3 R4 vec%0d wake", k), !stopped, v[0]);
            check($sformatf("R5 vec%0d no delay pulse", k), wake_rst, 0);
            if (stopped) ext_reset();
            tick(2);
        end

        // R2: flag survives rst_n, cleared by power-on
        @(negedge clk);
        check("R2 flag set after wake", cfg_rdata, 8'h80);
        ext_reset();
        @(negedge clk);
        check("R2 rst_n keeps flag", cfg_rdata, 8'h80);
        power_on();
        @(negedge clk);
        check("R2 power-on clears flag", cfg_rdata, 8'h00);

        // R5, R7: delayed wake with divide-by-16 on
        p3_in = 4'hF; p2_in = 8'hFF;
        write_cfg(7'h27); tick(4);
        pulse_stop();
        @(posedge clk); #1;
        p3_in = 4'hE;
        for (int i = 0; i < 10 && !wake_rst; i++) @(negedge clk);
        check("R5 wake_rst asserted", wake_rst, 1);
        hold = 0; s = 0;
        while (wake_rst) begin
            hold++;
            if (sclk_en || tclk_en) s++;
            @(negedge clk);
        end
        check("R5 hold length", hold, 64);
        check("R5 enables low in hold", s, 0);
        check("R2 flag after delayed wake", cfg_rdata, 8'h80);
        count_en(64, s, t);
        check("R7 divide-by-16 cleared", s, 64);

        // R5: no delay, enable on the cycle after wake
        p3_in = 4'hF;
        write_cfg(7'h06); tick(4);
        pulse_stop();
        @(posedge clk); #1;
        p3_in = 4'hE;
        for (int i = 0; i < 10 && stopped; i++) @(negedge clk);
        check("R5 immediate restart", sclk_en, 1);
        check("R5 no reset pulse", wake_rst, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule